// File: doc/BRIEF.md
# SCSI Target Phase Sequencer

This block is the bus-phase controller on the target side of a parallel SCSI link. It watches the initiator's selection, data-bus drive and acknowledge lines. It then steps through bus free, arbitration, selection, command, data in, data out, status and message in. While it does so it drives the target's BSY, REQ and the three phase lines (MSG, CD, IO), and it runs the REQ/ACK handshake one byte at a time. Byte storage and media access belong to other blocks.

A command decoder next to the sequencer decides the phase that follows the command phase, and when a data phase has finished. It does this through a one-cycle phase-request strobe. The strobe for the status phase also carries the status byte, which the sequencer presents on its data output until the initiator takes it. The handshake on that byte leads into a single message-in byte of 0x00, and then the bus is released. A one-cycle DMA-request pulse marks every entry into an information phase. All outputs are registered or decoded straight from registers.

Top module: `tgt_phase_seq`

## Requirements
- R1: While rst_n is low, and one clock edge after bus_rst_i is high in any state, the block is in bus free: phase_o = 0, bsy_o = 0, req_o = 0, drq_o = 0, and the phase lines are all low.
- R2: The phase lines {msg_o,cd_o,io_o} are as follows: command = 010, data in = 001, data out = 000, status = 011, message in = 111. Bus free, arbitration and selection drive 000. The phase_o codes are: 0 bus free, 1 arbitration, 2 selection, 3 command, 4 data in, 5 data out, 6 status, 7 message in.
- R3: In bus free or arbitration, with sel_i and data_drv_i high and data_i nonzero, the target ID is the index of the lowest set bit of data_i. If that ID is below NUM_IDS and its dev_present_i bit is set, then one edge later phase_o = 2, bsy_o = 1 and tgt_id_o equals that ID.
- R4: If the selected ID has no dev_present_i bit set, or is NUM_IDS or above, the block goes to bus free one edge later with bsy_o = 0.
- R5: A selection attempt with data_i = 0 raises sel_err_o for one cycle and leaves the block in bus free.
- R6: In selection, one edge after sel_i is low the block enters command with req_o = 1.
- R7: In command, data in and data out, when no phase change takes place, req_o equals the inverse of ack_i sampled at the previous edge.
- R8: Phase requests (ph_req_vld_i with ph_req_i: 0 = data in, 1 = data out, 2 = status, 3 = ignored) are accepted in command. In data in and data out only status is accepted, and all other requests leave the phase unchanged. On acceptance the new phase appears one edge later with req_o = 1.
- R9: In status, data_o shows the status byte latched from status_i with the request. After ACK has been seen high while REQ was high, and ACK is then low, the block enters message in with req_o = 1 and data_o = 0x00.
- R10: In message in, when ack_i and req_o are both low, the block goes to bus free one edge later and releases bsy_o and req_o.
- R11: drq_o is high for exactly one cycle, in the first cycle of each entry into command, data in, data out, status or message in, and is low at all other times.
- R12: In bus free, with no selection, arb_start_i moves the block to arbitration one edge later. In any other phase arb_start_i has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_rst_i | input | 1 | Synchronous bus reset, forces bus free |
| arb_start_i | input | 1 | Start arbitration from bus free |
| sel_i | input | 1 | Initiator SEL |
| data_drv_i | input | 1 | Initiator is driving the data bus |
| data_i | input | DATA_W | Data bus as seen by the target |
| ack_i | input | 1 | Initiator ACK |
| dev_present_i | input | NUM_IDS | One bit per target ID: a device exists |
| ph_req_vld_i | input | 1 | Phase-request strobe from the command decoder |
| ph_req_i | input | 2 | Requested phase code |
| status_i | input | DATA_W | Status byte sent with a status request |
| bsy_o | output | 1 | Target BSY |
| req_o | output | 1 | Target REQ |
| msg_o | output | 1 | MSG phase line |
| cd_o | output | 1 | C/D phase line |
| io_o | output | 1 | I/O phase line |
| drq_o | output | 1 | DMA-request pulse on entry into an information phase |
| sel_err_o | output | 1 | Selection with an empty data byte |
| tgt_id_o | output | $clog2(DATA_W) | ID captured at selection |
| phase_o | output | 3 | Current phase code |
| data_o | output | DATA_W | Status byte in status, 0x00 otherwise |

## Verification
The bench builds the block with DATA_W = 8 and NUM_IDS = 6. Bus values whose lowest set bit is 6 or 7 then name IDs that do not exist, so the out-of-range path of R4 is reached as well as the absent-device path. The bench runs all 256 data bytes against four presence masks, alternating between selection from bus free and from arbitration, and computes the lowest set bit arithmetically. Complete handshake flows then cover every phase-request code, the requests that are ignored, a stalled status byte and a bus reset in the middle of a phase.

// File: rtl/tps_pkg.sv
package tps_pkg;
   typedef enum logic [2:0] {
      PH_FREE = 3'd0,
      PH_ARB  = 3'd1,
      PH_SEL  = 3'd2,
      PH_CMD  = 3'd3,
      PH_DIN  = 3'd4,
      PH_DOUT = 3'd5,
      PH_STAT = 3'd6,
      PH_MSGI = 3'd7
   } phase_e;

   localparam logic [1:0] REQ_DIN  = 2'd0;
   localparam logic [1:0] REQ_DOUT = 2'd1;
   localparam logic [1:0] REQ_STAT = 2'd2;
endpackage

// File: rtl/tps_id_pick.sv
module tps_id_pick #(
   parameter int DATA_W = 8,
   localparam int IDW = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] vec_i,
   output logic              hit_o,
   output logic [IDW-1:0]    idx_o
);
   logic [DATA_W-1:0] first;

   genvar g;
   generate
      for (g = 0; g < DATA_W; g++) begin : g_first
         if (g == 0) begin : g_lsb
            assign first[g] = vec_i[0];
         end else begin : g_upper
            assign first[g] = vec_i[g] & ~(|vec_i[g-1:0]);
         end
      end
   endgenerate

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < DATA_W; i++) begin
         if (first[i]) idx_o = idx_o | IDW'(i);
      end
   end

   assign hit_o = |vec_i;
endmodule

// File: rtl/tps_phase_lines.sv
module tps_phase_lines
   import tps_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  phase_e            ph_i,
   input  logic [DATA_W-1:0] stat_i,
   output logic              msg_o,
   output logic              cd_o,
   output logic              io_o,
   output logic [DATA_W-1:0] data_o
);
   always_comb begin
      {msg_o, cd_o, io_o} = 3'b000;
      data_o = '0;
      unique case (ph_i)
         PH_CMD:  {msg_o, cd_o, io_o} = 3'b010;
         PH_DIN:  {msg_o, cd_o, io_o} = 3'b001;
         PH_DOUT: {msg_o, cd_o, io_o} = 3'b000;
         PH_STAT: begin
            {msg_o, cd_o, io_o} = 3'b011;
            data_o = stat_i;
         end
         PH_MSGI: {msg_o, cd_o, io_o} = 3'b111;
         default: {msg_o, cd_o, io_o} = 3'b000;
      endcase
   end
endmodule

// File: rtl/tgt_phase_seq.sv
module tgt_phase_seq
   import tps_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int NUM_IDS = 8,
   localparam int IDW = $clog2(DATA_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_rst_i,
   input  logic               arb_start_i,
   input  logic               sel_i,
   input  logic               data_drv_i,
   input  logic [DATA_W-1:0]  data_i,
   input  logic               ack_i,
   input  logic [NUM_IDS-1:0] dev_present_i,
   input  logic               ph_req_vld_i,
   input  logic [1:0]         ph_req_i,
   input  logic [DATA_W-1:0]  status_i,
   output logic               bsy_o,
   output logic               req_o,
   output logic               msg_o,
   output logic               cd_o,
   output logic               io_o,
   output logic               drq_o,
   output logic               sel_err_o,
   output logic [IDW-1:0]     tgt_id_o,
   output logic [2:0]         phase_o,
   output logic [DATA_W-1:0]  data_o
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (NUM_IDS < 1 || NUM_IDS > DATA_W) begin : g_bad_ids
         $error("NUM_IDS must lie in 1..DATA_W");
      end
   endgenerate

   phase_e            ph_q, ph_n, go_ph;
   logic              bsy_q, bsy_n, req_q, req_n, drq_q, drq_n, err_q, err_n;
   logic              taken_q, taken_n, go;
   logic [IDW-1:0]    id_q, id_n, pick_idx;
   logic [DATA_W-1:0] stat_q, stat_n;
   logic              pick_hit, pres;

   tps_id_pick #(.DATA_W(DATA_W)) u_pick (
      .vec_i (data_i),
      .hit_o (pick_hit),
      .idx_o (pick_idx)
   );

   always_comb begin
      pres = 1'b0;
      for (int i = 0; i < NUM_IDS; i++) begin
         if (pick_idx == IDW'(i)) pres = dev_present_i[i];
      end
   end

   always_comb begin
      ph_n    = ph_q;
      bsy_n   = bsy_q;
      req_n   = req_q;
      id_n    = id_q;
      stat_n  = stat_q;
      taken_n = taken_q;
      drq_n   = 1'b0;
      err_n   = 1'b0;
      go      = 1'b0;
      go_ph   = ph_q;
      if (ph_q inside {PH_CMD, PH_DIN, PH_DOUT, PH_STAT, PH_MSGI}) req_n = !ack_i;
      unique case (ph_q)
         PH_FREE, PH_ARB: begin
            if (sel_i && data_drv_i) begin
               if (!pick_hit) begin
                  err_n = 1'b1;
                  ph_n  = PH_FREE;
               end else if (!pres) begin
                  ph_n = PH_FREE;
               end else begin
                  ph_n  = PH_SEL;
                  bsy_n = 1'b1;
                  id_n  = pick_idx;
               end
            end else if (ph_q == PH_FREE && arb_start_i) begin
               ph_n = PH_ARB;
            end
         end
         PH_SEL: begin
            if (!sel_i) begin
               go    = 1'b1;
               go_ph = PH_CMD;
            end
         end
         PH_CMD: begin
            if (ph_req_vld_i) begin
               go = (ph_req_i != 2'd3);
               unique case (ph_req_i)
                  REQ_DIN:  go_ph = PH_DIN;
                  REQ_DOUT: go_ph = PH_DOUT;
                  REQ_STAT: go_ph = PH_STAT;
                  default:  go_ph = PH_CMD;
               endcase
            end
         end
         PH_DIN, PH_DOUT: begin
            if (ph_req_vld_i && ph_req_i == REQ_STAT) begin
               go    = 1'b1;
               go_ph = PH_STAT;
            end
         end
         PH_STAT: begin
            if (ack_i && req_q) taken_n = 1'b1;
            if (taken_q && !ack_i) begin
               go    = 1'b1;
               go_ph = PH_MSGI;
            end
         end
         PH_MSGI: begin
            if (!ack_i && !req_q) begin
               ph_n  = PH_FREE;
               bsy_n = 1'b0;
               req_n = 1'b0;
            end
         end
         default: ph_n = PH_FREE;
      endcase
      if (go) begin
         ph_n  = go_ph;
         req_n = 1'b1;
         drq_n = 1'b1;
         if (go_ph == PH_STAT) begin
            stat_n  = status_i;
            taken_n = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q    <= PH_FREE;
         bsy_q   <= 1'b0;
         req_q   <= 1'b0;
         drq_q   <= 1'b0;
         err_q   <= 1'b0;
         taken_q <= 1'b0;
         id_q    <= '0;
         stat_q  <= '0;
      end else if (bus_rst_i) begin
         ph_q    <= PH_FREE;
         bsy_q   <= 1'b0;
         req_q   <= 1'b0;
         drq_q   <= 1'b0;
         err_q   <= 1'b0;
         taken_q <= 1'b0;
         id_q    <= '0;
         stat_q  <= '0;
      end else begin
         ph_q    <= ph_n;
         bsy_q   <= bsy_n;
         req_q   <= req_n;
         drq_q   <= drq_n;
         err_q   <= err_n;
         taken_q <= taken_n;
         id_q    <= id_n;
         stat_q  <= stat_n;
      end
   end

   tps_phase_lines #(.DATA_W(DATA_W)) u_lines (
      .ph_i   (ph_q),
      .stat_i (stat_q),
      .msg_o  (msg_o),
      .cd_o   (cd_o),
      .io_o   (io_o),
      .data_o (data_o)
   );

   assign bsy_o     = bsy_q;
   assign req_o     = req_q;
   assign drq_o     = drq_q;
   assign sel_err_o = err_q;
   assign tgt_id_o  = id_q;
   assign phase_o   = ph_q;
endmodule

// File: rtl/tps_chk.sv
module tps_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_rst_i,
   input logic       arb_start_i,
   input logic       sel_i,
   input logic       ack_i,
   input logic       ph_req_vld_i,
   input logic       bsy_o,
   input logic       req_o,
   input logic       msg_o,
   input logic       cd_o,
   input logic       io_o,
   input logic       drq_o,
   input logic       sel_err_o,
   input logic [2:0] phase_o
);
   a_r1_bus_reset: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst_i |=> (phase_o == 3'd0 && !bsy_o && !req_o && !drq_o));

   a_r2_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o <= 3'd2) |-> ({msg_o, cd_o, io_o} == 3'b000));

   a_r3_sel_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == 3'd2) |-> bsy_o);

   a_r5_err_free: assert property (@(posedge clk) disable iff (!rst_n)
      sel_err_o |-> (phase_o == 3'd0));

   a_r6_sel_release: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == 3'd2 && !sel_i && !bus_rst_i) |=> (phase_o == 3'd3 && req_o));

   a_r7_req_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o inside {3'd3, 3'd4, 3'd5} && !ph_req_vld_i && !bus_rst_i)
      |=> (req_o == !$past(ack_i)));

   a_r10_free_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == 3'd0) |-> (!bsy_o && !req_o));

   a_r11_drq_entry: assert property (@(posedge clk) disable iff (!rst_n)
      drq_o |-> (phase_o >= 3'd3 && phase_o != $past(phase_o)));

   a_r12_arb_enter: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == 3'd0 && arb_start_i && !sel_i && !bus_rst_i) |=> (phase_o == 3'd1));
endmodule

bind tgt_phase_seq tps_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_rst_i    (bus_rst_i),
   .arb_start_i  (arb_start_i),
   .sel_i        (sel_i),
   .ack_i        (ack_i),
   .ph_req_vld_i (ph_req_vld_i),
   .bsy_o        (bsy_o),
   .req_o        (req_o),
   .msg_o        (msg_o),
   .cd_o         (cd_o),
   .io_o         (io_o),
   .drq_o        (drq_o),
   .sel_err_o    (sel_err_o),
   .phase_o      (phase_o)
);

// File: tb/sim_tgt_phase_seq.sv
module sim_tgt_phase_seq;
   localparam int DW  = 8;
   localparam int NID = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_rst_i = 1'b0, arb_start_i = 1'b0, sel_i = 1'b0, data_drv_i = 1'b0;
   logic ack_i = 1'b0, ph_req_vld_i = 1'b0;
   logic [DW-1:0]  data_i = '0, status_i = '0;
   logic [NID-1:0] dev_present_i = '0;
   logic [1:0]     ph_req_i = '0;
   logic bsy_o, req_o, msg_o, cd_o, io_o, drq_o, sel_err_o;
   logic [2:0]     tgt_id_o, phase_o;
   logic [DW-1:0]  data_o;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   tgt_phase_seq #(.DATA_W(DW), .NUM_IDS(NID)) u0 (.*);

   task automatic check(input int act, input int exp, input string tag);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic int lines_of(input int ph);
      case (ph)
         3: return 3'b010;
         4: return 3'b001;
         6: return 3'b011;
         7: return 3'b111;
         default: return 0;
      endcase
   endfunction

   task automatic chk_phase(input int ph, input string tag);
      check(int'(phase_o), ph, tag);
      check(int'({msg_o, cd_o, io_o}), lines_of(ph), {tag, " lines R2"});
   endtask

   task automatic bus_reset();
      bus_rst_i = 1'b1; sel_i = 1'b0; data_drv_i = 1'b0; ack_i = 1'b0;
      ph_req_vld_i = 1'b0; arb_start_i = 1'b0;
      step();
      bus_rst_i = 1'b0;
   endtask

   task automatic select_cmd(input int id);
      bus_reset();
      dev_present_i = '1;
      sel_i = 1'b1; data_drv_i = 1'b1; data_i = DW'(1 << id);
      step();
      chk_phase(2, "R3 sel");
      sel_i = 1'b0; data_drv_i = 1'b0;
      step();
      chk_phase(3, "R6 cmd");
      check(req_o, 1, "R6 req");
      check(drq_o, 1, "R11 drq cmd");
      step();
      check(drq_o, 0, "R11 drq one cycle");
   endtask

   task automatic request(input int code);
      ph_req_vld_i = 1'b1; ph_req_i = 2'(code);
      step();
      ph_req_vld_i = 1'b0;
   endtask

   task automatic status_and_exit(input int sb);
      check(int'(data_o), sb, "R9 status byte");
      ack_i = 1'b1; step();
      check(req_o, 0, "R7 req drop status");
      chk_phase(6, "R9 still status");
      ack_i = 1'b0; step();
      chk_phase(7, "R9 msg in");
      check(req_o, 1, "R9 req msg");
      check(int'(data_o), 0, "R9 msg byte");
      check(drq_o, 1, "R11 drq msg");
      ack_i = 1'b1; step();
      check(req_o, 0, "R7 req drop msg");
      chk_phase(7, "R10 hold msg");
      ack_i = 1'b0; step();
      chk_phase(0, "R10 free");
      check(bsy_o, 0, "R10 bsy");
      check(req_o, 0, "R10 req");
   endtask

   initial begin
      repeat (2) @(negedge clk);
      chk_phase(0, "R1 reset phase");
      check(bsy_o, 0, "R1 reset bsy");
      check(req_o, 0, "R1 reset req");
      check(drq_o, 0, "R1 reset drq");
      rst_n = 1'b1;
      step();

      // R3 R4 R5 R12: exhaustive selection sweep
      for (int m = 0; m < 4; m++) begin
         for (int d = 0; d < 256; d++) begin
            logic [NID-1:0] mask;
            int lo, exp_ph;
            mask = (m == 0) ? 6'h3F : (m == 1) ? 6'h15 : (m == 2) ? 6'h2A : 6'h00;
            bus_reset();
            dev_present_i = mask;
            if (d % 2 == 1) begin
               arb_start_i = 1'b1; step(); arb_start_i = 1'b0;
               chk_phase(1, "R12 arb");
            end
            sel_i = 1'b1; data_drv_i = 1'b1; data_i = DW'(d);
            step();
            lo = -1;
            for (int k = 7; k >= 0; k--) if (((d >> k) & 1) == 1) lo = k;
            exp_ph = (lo >= 0 && lo < NID && mask[lo % NID] == 1'b1) ? 2 : 0;
            chk_phase(exp_ph, "R3/R4 sweep");
            check(bsy_o, (exp_ph == 2) ? 1 : 0, "R4 bsy sweep");
            check(sel_err_o, (d == 0) ? 1 : 0, "R5 err");
            if (exp_ph == 2) check(int'(tgt_id_o), lo, "R3 id");
            sel_i = 1'b0; data_drv_i = 1'b0;
            if (d == 0) begin
               step();
               check(sel_err_o, 0, "R5 err one cycle");
            end
         end
      end

      // R12: arb_start ignored in command
      select_cmd(2);
      arb_start_i = 1'b1; step(); arb_start_i = 1'b0;
      chk_phase(3, "R12 ignored in cmd");

      // R7: REQ tracks inverse ACK in command
      ack_i = 1'b1; step();
      check(req_o, 0, "R7 req low");
      ack_i = 1'b0; step();
      check(req_o, 1, "R7 req high");

      // R8: reserved code ignored, then data in
      request(3);
      chk_phase(3, "R8 reserved ignored");
      check(drq_o, 0, "R11 no drq reserved");
      request(0);
      chk_phase(4, "R8 data in");
      check(req_o, 1, "R8 req din");
      check(drq_o, 1, "R11 drq din");
      request(1);
      chk_phase(4, "R8 dout ignored in din");
      request(0);
      chk_phase(4, "R8 din ignored in din");
      status_i = 8'h5A;
      request(2);
      chk_phase(6, "R8 status");
      check(drq_o, 1, "R11 drq status");
      status_and_exit(8'h5A);

      // data out path
      select_cmd(0);
      request(1);
      chk_phase(5, "R8 data out");
      check(drq_o, 1, "R11 drq dout");
      ack_i = 1'b1; step();
      check(req_o, 0, "R7 dout req low");
      ack_i = 1'b0; step();
      check(req_o, 1, "R7 dout req high");
      status_i = 8'h02;
      request(2);
      chk_phase(6, "R8 status from dout");
      // stalled status: no ACK keeps status
      step(); step();
      chk_phase(6, "R9 stall");
      status_and_exit(2);

      // command straight to status
      select_cmd(5);
      check(int'(tgt_id_o), 5, "R3 id 5");
      status_i = 8'hC3;
      request(2);
      chk_phase(6, "R8 cmd to status");
      status_and_exit(8'hC3);

      // R1: bus reset mid data phase
      select_cmd(1);
      request(0);
      bus_rst_i = 1'b1; step(); bus_rst_i = 1'b0;
      chk_phase(0, "R1 bus reset");
      check(bsy_o, 0, "R1 bus reset bsy");
      check(req_o, 0, "R1 bus reset req");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule